// File: doc/BRIEF.md
# PWM Loopback Compare Checker

This block watches a one-bit PWM link that crosses between two domains. The local side registers the PWM command and sends it as `tx_o`. The far side returns every level it receives as `echo_i`. The checker delays its own copy of the sent level by the round-trip latency. It then compares that copy with the returned level on every clock, so a fault is caught on steady levels as well as at transitions. The check is digital only and does not use any power-stage or output voltage.

Any disagreement sets a sticky mismatch flag. The flag stays set until software-side logic pulses the clear input. A fault request output passes the mismatch flag on only while the enable input is high. A second sticky flag reports PWM input that runs faster than the supported rate. That rate is 50 kHz, which means rising edges less than 20 µs apart (4000 cycles at 200 MHz by default). For the first round-trip latency after reset no comparison is made, because the link may still hold stale values.

Top module: `pwm_echo_chk`

## Requirements
- R1: `tx_o` equals the value of `pwm_i` sampled at the previous rising clock edge.
- R2: When armed, if `echo_i` differs from `tx_o` delayed by RT_LAT cycles at a clock edge, `mism_o` is 1 after that edge, whether the levels are steady or toggling.
- R3: While `echo_i` always equals `tx_o` delayed by RT_LAT cycles, `mism_o` stays 0 for any PWM pattern.
- R4: Mismatches seen at the first RT_LAT clock edges after reset release are ignored. The first edge that checks is edge RT_LAT+1.
- R5: `mism_o` and `ovspd_o` stay set until an edge at which `clr_i` is 1. That edge drops them to 0 unless a new event occurs in the same cycle.
- R6: When a new mismatch and `clr_i` fall in the same cycle, `mism_o` is 1 after that edge.
- R7: `fault_req_o` is `mism_o` AND `fault_en_i`, combinational in the enable. With the enable at 0 the output is 0 and `mism_o` keeps its state.
- R8: If two rising edges of `pwm_i` (as seen at clock edges) are fewer than MIN_PER_CYC cycles apart, `ovspd_o` is set. A spacing of exactly MIN_PER_CYC does not set it.
- R9: The first rising edge of `pwm_i` after reset never sets `ovspd_o`. The overspeed flag does not affect `mism_o` or `fault_req_o`.
- R10: While reset is asserted, `tx_o`, `mism_o`, `ovspd_o` and `fault_req_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | PWM command level |
| echo_i | input | 1 | Level returned by the far side of the link |
| fault_en_i | input | 1 | Enables the fault request |
| clr_i | input | 1 | Clears both sticky flags |
| tx_o | output | 1 | Level sent across the link |
| mism_o | output | 1 | Sticky loopback mismatch flag |
| ovspd_o | output | 1 | Sticky PWM overspeed flag |
| fault_req_o | output | 1 | Gated fault request |

## Verification
The clear of the sticky mismatch flag and the detection of a fresh mismatch can land on the same clock edge. To provoke this, the bench drives `clr_i` high in the same cycle that it inverts the modelled echo. The edge is judged by reading `mism_o` just after it: a 1 shows that the new event was kept. The same vector walk also puts a rising PWM edge spaced below the rate limit next to a clear cycle, so the overspeed flag is seen to re-arm only from a real event.

// File: rtl/pwm_echo_pkg.sv
package pwm_echo_pkg;

   // Index of each sticky flag inside the flag vector
   typedef enum int unsigned {
      FLG_MISM  = 0,
      FLG_OVSPD = 1
   } flag_idx_e;

   localparam int unsigned NUM_FLAGS = 2;

   typedef struct packed {
      logic ovspd;
      logic mism;
   } chk_flags_t;

endpackage

// File: rtl/pwm_echo_align.sv
module pwm_echo_align #(
   parameter int unsigned RT_LAT = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tx_i,
   output logic exp_o,
   output logic armed_o
);

   generate
      if (RT_LAT > 64) begin : g_bad_lat
         $error("pwm_echo_align: RT_LAT must not exceed 64");
      end

      if (RT_LAT == 0) begin : g_direct
         // Echo arrives in the same cycle: compare directly, always armed
         assign exp_o   = tx_i;
         assign armed_o = 1'b1;
      end else begin : g_line
         localparam int unsigned CW = $clog2(RT_LAT + 1);
         localparam logic [CW-1:0] ARM_END = CW'(RT_LAT);

         logic [RT_LAT-1:0] line_q;
         logic [CW-1:0]     arm_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               line_q <= '0;
            end else begin
               line_q[0] <= tx_i;
               for (int i = 1; i < int'(RT_LAT); i++) begin
                  line_q[i] <= line_q[i-1];
               end
            end
         end

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               arm_q <= '0;
            end else if (arm_q != ARM_END) begin
               arm_q <= arm_q + CW'(1);
            end
         end

         assign exp_o   = line_q[RT_LAT-1];
         assign armed_o = (arm_q == ARM_END);

         // Once armed, the window never closes again until reset
         AST_ARM_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            armed_o |=> armed_o); // R4
      end
   endgenerate

endmodule

// File: rtl/pwm_echo_rate.sv
module pwm_echo_rate #(
   parameter int unsigned MIN_PER_CYC = 4000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pwm_i,
   input  logic prev_i,
   output logic hit_o
);

   localparam int unsigned CW = $clog2(MIN_PER_CYC + 1);
   localparam logic [CW-1:0] CNT_MAX = CW'(MIN_PER_CYC);

   generate
      if (MIN_PER_CYC < 2) begin : g_bad_per
         $error("pwm_echo_rate: MIN_PER_CYC must be at least 2");
      end
   endgenerate

   logic          rise;
   logic          seen_q;
   logic [CW-1:0] cnt_q;

   assign rise = pwm_i & ~prev_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         seen_q <= 1'b0;
         cnt_q  <= '0;
      end else if (rise) begin
         seen_q <= 1'b1;
         cnt_q  <= CW'(1);
      end else if (cnt_q != CNT_MAX) begin
         cnt_q  <= cnt_q + CW'(1);
      end
   end

   assign hit_o = rise & seen_q & (cnt_q < CNT_MAX);

   always @(posedge clk_i) begin
      if (rst_ni) begin
         AST_CNT_BOUND: assert (cnt_q <= CNT_MAX); // R8
      end
   end

   // The first edge after reset can never count as overspeed
   AST_FIRST_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise && !seen_q) |-> !hit_o); // R9

endmodule

// File: rtl/pwm_echo_sticky.sv
module pwm_echo_sticky (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         q_o <= 1'b0;
      end else begin
         q_o <= set_i | (q_o & ~clr_i);
      end
   end

   AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_o && !clr_i) |=> q_o); // R5
   AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !set_i) |=> !q_o); // R5
   AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i |=> q_o); // R6

endmodule

// File: rtl/pwm_echo_chk.sv
module pwm_echo_chk
   import pwm_echo_pkg::*;
#(
   parameter int unsigned RT_LAT      = 3,
   parameter int unsigned MIN_PER_CYC = 4000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pwm_i,
   input  logic echo_i,
   input  logic fault_en_i,
   input  logic clr_i,
   output logic tx_o,
   output logic mism_o,
   output logic ovspd_o,
   output logic fault_req_o
);

   logic       tx_q;
   logic       exp_lvl;
   logic       armed;
   logic       rate_hit;
   chk_flags_t set_vec;
   chk_flags_t flag_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tx_q <= 1'b0;
      end else begin
         tx_q <= pwm_i;
      end
   end

   pwm_echo_align #(.RT_LAT(RT_LAT)) u_align (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tx_i    (tx_q),
      .exp_o   (exp_lvl),
      .armed_o (armed)
   );

   pwm_echo_rate #(.MIN_PER_CYC(MIN_PER_CYC)) u_rate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pwm_i  (pwm_i),
      .prev_i (tx_q),
      .hit_o  (rate_hit)
   );

   assign set_vec.mism  = armed & (exp_lvl ^ echo_i);
   assign set_vec.ovspd = rate_hit;

   generate
      for (genvar g = 0; g < int'(NUM_FLAGS); g++) begin : g_flag
         pwm_echo_sticky u_sticky (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .set_i  (set_vec[g]),
            .clr_i  (clr_i),
            .q_o    (flag_q[g])
         );
      end
   endgenerate

   assign tx_o        = tx_q;
   assign mism_o      = flag_q.mism;
   assign ovspd_o     = flag_q.ovspd;
   assign fault_req_o = flag_q.mism & fault_en_i;

   AST_TX_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (tx_o == $past(pwm_i))); // R1
   AST_NO_EARLY_MISM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(mism_o) |-> $past(armed)); // R4
   AST_FAULT_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_req_o |-> mism_o); // R7
   AST_OVSPD_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ovspd_o) |-> $past(pwm_i && !tx_o)); // R8

endmodule

// File: tb/pwm_echo_chk_tb.sv
module pwm_echo_chk_tb;

   localparam int LAT  = 3;
   localparam int MINP = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwm = 1'b0, flip = 1'b0, en = 1'b0, clr = 1'b0;
   logic tx, mism, ovspd, freq, echo;
   logic [LAT-1:0] link = '1;
   int   n_chk = 0, n_err = 0;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;

   // Link model: frozen during reset, stale ones at start
   always_ff @(posedge clk) if (rst_n) link <= {link[LAT-2:0], tx};
   assign echo = link[LAT-1] ^ flip;

   pwm_echo_chk #(.RT_LAT(LAT), .MIN_PER_CYC(MINP)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .pwm_i(pwm), .echo_i(echo),
      .fault_en_i(en), .clr_i(clr), .tx_o(tx), .mism_o(mism),
      .ovspd_o(ovspd), .fault_req_o(freq)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic step(input logic p, input logic f, input logic e, input logic c);
      @(negedge clk);
      pwm = p; flip = f; en = e; clr = c;
      @(posedge clk);
      #1;
   endtask

   // columns: pwm flip en clr | mism ovspd
   localparam logic [5:0] VEC [12] = '{
      6'b1010_00, 6'b0010_00, 6'b1010_01, 6'b1110_11,
      6'b1010_11, 6'b1000_11, 6'b0001_00, 6'b0111_10,
      6'b0011_00, 6'b1010_01, 6'b0010_01, 6'b1010_01
   };

   initial begin
      // R10 reset state
      repeat (3) @(posedge clk);
      #1;
      chk("R10 tx", tx, 1'b0);
      chk("R10 mism", mism, 1'b0);
      chk("R10 ovspd", ovspd, 1'b0);
      chk("R10 fault", freq, 1'b0);
      @(negedge clk); rst_n = 1'b1;
      // R4: stale echo during the arming window is ignored
      for (int i = 0; i < LAT + 2; i++) begin
         @(posedge clk); #1;
         chk("R4 unarmed", mism, 1'b0);
      end
      // vector walk: R1 R2 R5 R6 R7 R8 R9
      for (int i = 0; i < 12; i++) begin
         step(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
         chk("R1 tx", tx, VEC[i][5]);
         chk("R2/R5/R6 mism", mism, VEC[i][1]);
         chk("R7 fault", freq, VEC[i][1] & VEC[i][3]);
         chk("R8/R9 ovspd", ovspd, VEC[i][0]);
      end
      step(1'b0, 1'b0, 1'b1, 1'b1);
      chk("R5 clear", mism, 1'b0);
      // R3: matching echo over a pseudo-random pattern
      begin
         logic [7:0] lf = 8'hA5;
         for (int i = 0; i < 120; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            step(lf[0], 1'b0, 1'b1, 1'b0);
         end
      end
      chk("R3 no mismatch", mism, 1'b0);
      chk("R3 no fault", freq, 1'b0);
      // R8 boundary: spacing MINP passes, MINP-1 flags
      step(1'b0, 1'b0, 1'b1, 1'b1);
      repeat (MINP + 10) step(1'b0, 1'b0, 1'b1, 1'b0);
      chk("R5 ovspd cleared", ovspd, 1'b0);
      step(1'b1, 1'b0, 1'b1, 1'b0);
      repeat (MINP - 1) step(1'b0, 1'b0, 1'b1, 1'b0);
      step(1'b1, 1'b0, 1'b1, 1'b0);
      chk("R8 spacing equal", ovspd, 1'b0);
      repeat (MINP - 2) step(1'b0, 1'b0, 1'b1, 1'b0);
      step(1'b1, 1'b0, 1'b1, 1'b0);
      chk("R8 spacing short", ovspd, 1'b1);
      chk("R9 mism untouched", mism, 1'b0);
      chk("R9 fault untouched", freq, 1'b0);
      // R10 reset mid-run
      @(negedge clk); rst_n = 1'b0;
      #1;
      chk("R10 reset ovspd", ovspd, 1'b0);
      chk("R10 reset tx", tx, 1'b0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule